// File: doc/BRIEF.md
# Serial Flash Command Receiver

This block is the device-side front end of a serial flash command port. It watches a serial clock, an active-low select and a serial data line, all of which arrive asynchronously to the system clock. While select is low it captures one data bit on each rising serial-clock edge, most significant bit first. The first eight bits of a frame form the command opcode. The next twenty-four bits form the address field.

Once the address field is complete, the block splits it into a page number and a byte offset. A mode input chooses between two layouts. In the first, pages are 264 bytes and the byte field is 9 bits wide. In the second, pages are 256 bytes and the byte field is 8 bits wide. The block also reports which 8-page block holds the addressed page. It reports which sector holds that page too, where the first sector is divided into a small and a large part.

Downstream control logic uses the two single-cycle strobes to start its command and data handling. Every bit after the address field belongs to the data phase, which this block ignores. The serial link cannot be stalled, so the outputs are plain strobes with no ready input and no back-pressure. A consumer must capture the values when the strobe fires. The values then hold until the next strobe.

Top module: `sflash_cmd_front`

## Requirements
- R1: After reset, `op_valid` and `addr_valid` are 0, and `opcode`, `page`, `byte_off`, `byte_oor`, `sector_idx` and `block_idx` are all 0.
- R2: The first 8 bits sampled in a frame are assembled MSB first into `opcode`. `op_valid` pulses high for exactly one clock cycle per frame. A frame that ends before its 8th bit produces no `op_valid`.
- R3: The 24 bits that follow the opcode are assembled MSB first into the address field. `addr_valid` pulses high for exactly one clock cycle once per frame. Bits after the 32nd produce no further strobe.
- R4: A rising edge on `cs_n` discards a partial frame, and the next frame starts again at bit 0. Serial-clock edges while `cs_n` is high have no effect.
- R5: With `mode_bin`=0 (264-byte pages), `byte_off` = address bits [8:0] and `page` = address bits [18:9]. Address bits [23:19] are ignored.
- R6: With `mode_bin`=1 (256-byte pages), `byte_off` = {0, address bits [7:0]} and `page` = address bits [17:8]. Address bits [23:18] are ignored.
- R7: `byte_oor` is 1 exactly when `mode_bin`=0 and `byte_off` >= 264. It is always 0 when `mode_bin`=1.
- R8: `sector_idx` is 0 for pages 0..7, 1 for pages 8..127, and 1 + page[9:7] for pages 128..1023. The last case gives the values 2..8.
- R9: `block_idx` = page / 8, which is page[9:3].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock, asynchronous to `clk` |
| cs_n | input | 1 | Active-low frame select, asynchronous |
| si | input | 1 | Serial data in, sampled on `sck` rising edge |
| mode_bin | input | 1 | 1 = 256-byte pages, 0 = 264-byte pages |
| op_valid | output | 1 | One-cycle strobe when `opcode` is updated |
| opcode | output | 8 | Last received opcode |
| addr_valid | output | 1 | One-cycle strobe when the decoded address outputs are updated |
| page | output | 10 | Page number |
| byte_off | output | 9 | Byte offset within the page |
| byte_oor | output | 1 | Byte offset beyond the 264-byte page |
| sector_idx | output | 4 | Sector index (0 = small part of sector 0, 1 = rest of sector 0, 2..8 = sectors 1..7) |
| block_idx | output | 7 | 8-page block index |

## Verification
The checks assume that each `sck` level lasts several `clk` cycles, longer than the synchronizer delay, so that every rising edge is seen exactly once. They also assume that `si` is settled before the `sck` rising edge and that `mode_bin` stays steady through a frame. The stimulus holds each `sck` level for four clock cycles. It changes `si` only while `sck` is low, and it sets `mode_bin` before `cs_n` falls. The strobe-width and mode-dependent properties only make sense under these input rules.

// File: rtl/sfcf_pkg.sv
package sfcf_pkg;
  localparam int OP_W       = 8;
  localparam int ADDR_W     = 24;
  localparam int PAGE_W     = 10;
  localparam int BYTE_W     = 9;
  localparam int PAGE_BYTES = 264;
  localparam int BLK_PAGES  = 8;
  localparam int SUB0_PAGES = 8;
  localparam int SEC_PAGES  = 128;
  localparam int SEC_W      = $clog2(2 + (1 << PAGE_W) / SEC_PAGES);
  localparam int BLK_W      = PAGE_W - $clog2(BLK_PAGES);

  typedef struct packed {
    logic [PAGE_W-1:0] page;
    logic [BYTE_W-1:0] byte_off;
    logic              oor;
    logic [SEC_W-1:0]  sector;
    logic [BLK_W-1:0]  block;
  } loc_t;
endpackage

// File: rtl/sfcf_sync.sv
module sfcf_sync #(
  parameter int               STAGES  = 2,
  parameter int               WIDTH   = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/sfcf_shift.sv
module sfcf_shift #(
  parameter int OP_W   = 8,
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_s,
  input  logic              csn_s,
  input  logic              si_s,
  output logic              op_done,
  output logic [OP_W-1:0]   opcode,
  output logic              addr_done,
  output logic [ADDR_W-1:0] addr_word
);
  localparam int FRAME_W = OP_W + ADDR_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic              sck_d;
  logic              rise;
  logic [CNT_W-1:0]  bit_cnt;
  logic [ADDR_W-1:0] sr;
  logic [ADDR_W-1:0] shift_nx;
  logic              taking;

  assign rise     = sck_s & ~sck_d & ~csn_s;
  assign taking   = rise && (bit_cnt < CNT_W'(FRAME_W));
  assign shift_nx = {sr[ADDR_W-2:0], si_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d     <= 1'b0;
      bit_cnt   <= '0;
      sr        <= '0;
      op_done   <= 1'b0;
      addr_done <= 1'b0;
      opcode    <= '0;
      addr_word <= '0;
    end else begin
      sck_d     <= sck_s;
      op_done   <= 1'b0;
      addr_done <= 1'b0;
      if (csn_s) begin
        bit_cnt <= '0;
        sr      <= '0;
      end else if (taking) begin
        sr      <= shift_nx;
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == CNT_W'(OP_W - 1)) begin
          op_done <= 1'b1;
          opcode  <= shift_nx[OP_W-1:0];
        end
        if (bit_cnt == CNT_W'(FRAME_W - 1)) begin
          addr_done <= 1'b1;
          addr_word <= shift_nx;
        end
      end
    end
  end

  p_op_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> !op_done);
  p_addr_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    addr_done |=> !addr_done);
  p_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_done && addr_done));
  p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (csn_s && $past(csn_s)) |-> (!op_done && !addr_done));
endmodule

// File: rtl/sfcf_decode.sv
module sfcf_decode
  import sfcf_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_bin,
  input  logic              valid_in,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              valid,
  output loc_t              loc
);
  localparam int SEC_SH = $clog2(SEC_PAGES);
  localparam int BLK_SH = $clog2(BLK_PAGES);

  logic [PAGE_W-1:0] pg;
  logic [BYTE_W-1:0] by;
  logic              oor;
  logic [SEC_W-1:0]  sec;
  logic              unused_hi;

  assign unused_hi = ^addr_in[ADDR_W-1:BYTE_W+PAGE_W];

  always_comb begin
    if (mode_bin) begin
      pg = addr_in[BYTE_W-1 +: PAGE_W];
      by = {1'b0, addr_in[BYTE_W-2:0]};
    end else begin
      pg = addr_in[BYTE_W +: PAGE_W];
      by = addr_in[BYTE_W-1:0];
    end
    oor = !mode_bin && (by >= BYTE_W'(PAGE_BYTES));
    if (pg < PAGE_W'(SUB0_PAGES))      sec = '0;
    else if (pg < PAGE_W'(SEC_PAGES))  sec = SEC_W'(1);
    else                               sec = SEC_W'(1) + SEC_W'(pg >> SEC_SH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      loc   <= '0;
    end else begin
      valid <= valid_in;
      if (valid_in) begin
        loc.page     <= pg;
        loc.byte_off <= by;
        loc.oor      <= oor;
        loc.sector   <= sec;
        loc.block    <= pg[PAGE_W-1:BLK_SH];
      end
    end
  end

  p_bin_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && mode_bin) |-> !loc.byte_off[BYTE_W-1]);
  p_oor_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && mode_bin) |-> !loc.oor);
  p_sub0_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && loc.page < PAGE_W'(SUB0_PAGES)) |-> loc.sector == '0);
  p_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (loc.block == loc.page[PAGE_W-1:BLK_SH]));
endmodule

// File: rtl/sflash_cmd_front.sv
module sflash_cmd_front
  import sfcf_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              si,
  input  logic              mode_bin,
  output logic              op_valid,
  output logic [OP_W-1:0]   opcode,
  output logic              addr_valid,
  output logic [PAGE_W-1:0] page,
  output logic [BYTE_W-1:0] byte_off,
  output logic              byte_oor,
  output logic [SEC_W-1:0]  sector_idx,
  output logic [BLK_W-1:0]  block_idx
);
  logic              sck_s, si_s, csn_s;
  logic              addr_done;
  logic [ADDR_W-1:0] addr_word;
  loc_t              loc;

  sfcf_sync #(.STAGES(SYNC_STAGES), .WIDTH(2), .RST_VAL(2'b00)) u_sync_d (
    .clk(clk), .rst_n(rst_n), .d({sck, si}), .q({sck_s, si_s}));

  sfcf_sync #(.STAGES(SYNC_STAGES), .WIDTH(1), .RST_VAL(1'b1)) u_sync_cs (
    .clk(clk), .rst_n(rst_n), .d(cs_n), .q(csn_s));

  sfcf_shift #(.OP_W(OP_W), .ADDR_W(ADDR_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .sck_s(sck_s), .csn_s(csn_s), .si_s(si_s),
    .op_done(op_valid), .opcode(opcode),
    .addr_done(addr_done), .addr_word(addr_word));

  sfcf_decode #(.ADDR_W(ADDR_W)) u_decode (
    .clk(clk), .rst_n(rst_n), .mode_bin(mode_bin), .valid_in(addr_done),
    .addr_in(addr_word), .valid(addr_valid), .loc(loc));

  assign page       = loc.page;
  assign byte_off   = loc.byte_off;
  assign byte_oor   = loc.oor;
  assign sector_idx = loc.sector;
  assign block_idx  = loc.block;
endmodule

// File: tb/sflash_cmd_front_bench.sv
module sflash_cmd_front_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, mode_bin = 1'b0;
  logic op_valid, addr_valid, byte_oor;
  logic [7:0] opcode;
  logic [9:0] page;
  logic [8:0] byte_off;
  logic [3:0] sector_idx;
  logic [6:0] block_idx;

  int n_chk = 0, n_bad = 0;
  int op_cnt = 0, ad_cnt = 0;
  logic [7:0] op_seen;
  logic [9:0] pg_seen;
  logic [8:0] by_seen;
  logic oor_seen;
  logic [3:0] sec_seen;
  logic [6:0] blk_seen;

  always #10 clk = ~clk;

  sflash_cmd_front u_sflash_cmd_front (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
    .mode_bin(mode_bin), .op_valid(op_valid), .opcode(opcode),
    .addr_valid(addr_valid), .page(page), .byte_off(byte_off),
    .byte_oor(byte_oor), .sector_idx(sector_idx), .block_idx(block_idx));

  always @(negedge clk) begin
    if (op_valid) begin op_cnt++; op_seen = opcode; end
    if (addr_valid) begin
      ad_cnt++; pg_seen = page; by_seen = byte_off; oor_seen = byte_oor;
      sec_seen = sector_idx; blk_seen = block_idx;
    end
  end

  // {mode, opcode, addr, page, byte, oor, sector, block}
  localparam logic [63:0] VEC [9] = '{
    {1'b0, 8'h52, 24'h000A03, 10'd5,   9'd3,   1'b0, 4'd0, 7'd0},   // R5 R8 sub0
    {1'b0, 8'hD2, 24'h001107, 10'd8,   9'd263, 1'b0, 4'd1, 7'd1},   // R7 edge 263
    {1'b0, 8'h81, 24'h00FF08, 10'd127, 9'd264, 1'b1, 4'd1, 7'd15},  // R7 edge 264
    {1'b0, 8'h0B, 24'h010000, 10'd128, 9'd0,   1'b0, 4'd2, 7'd16},  // R8 sector 1
    {1'b0, 8'hE8, 24'hF7FFFF, 10'd1023,9'd511, 1'b1, 4'd8, 7'd127}, // R5 high bits
    {1'b1, 8'h53, 24'h0007FF, 10'd7,   9'd255, 1'b0, 4'd0, 7'd0},   // R6
    {1'b1, 8'hA5, 24'hFD2C10, 10'd300, 9'd16,  1'b0, 4'd3, 7'd37},  // R6 high bits
    {1'b1, 8'h3C, 24'h038080, 10'd896, 9'd128, 1'b0, 4'd8, 7'd112}, // R8 last
    {1'b1, 8'hFF, 24'h0080F0, 10'd128, 9'd240, 1'b0, 4'd2, 7'd16}   // R9
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sck_toggle(input int n);
    for (int i = 0; i < n; i++) begin
      repeat (4) @(negedge clk); sck = 1'b1;
      repeat (4) @(negedge clk); sck = 1'b0;
    end
  endtask

  task automatic frame(input logic md, input logic [47:0] bits, input int nbits);
    @(negedge clk);
    mode_bin = md;
    op_cnt = 0; ad_cnt = 0;
    repeat (2) @(negedge clk);
    cs_n = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      repeat (4) @(negedge clk); si = bits[47-i];
      repeat (4) @(negedge clk); sck = 1'b1;
      repeat (4) @(negedge clk); sck = 1'b0;
    end
    repeat (4) @(negedge clk);
    cs_n = 1'b1; si = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 op_valid", op_valid, 0);
    check("R1 addr_valid", addr_valid, 0);
    check("R1 opcode", opcode, 0);
    check("R1 page", page, 0);
    check("R1 byte_off", byte_off, 0);
    check("R1 sector", sector_idx, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int v = 0; v < 9; v++) begin
      logic [63:0] e;
      e = VEC[v];
      frame(e[63], {e[62:31], 16'h0}, 32);
      check("R2 op pulses", op_cnt, 1);
      check("R2 opcode", op_seen, int'(e[62:55]));
      check("R3 addr pulses", ad_cnt, 1);
      check(e[63] ? "R6 page" : "R5 page", pg_seen, int'(e[30:21]));
      check(e[63] ? "R6 byte" : "R5 byte", by_seen, int'(e[20:12]));
      check("R7 oor", oor_seen, int'(e[11]));
      check("R8 sector", sec_seen, int'(e[10:7]));
      check("R9 block", blk_seen, int'(e[6:0]));
    end

    // R4: serial clock with select high does nothing
    op_cnt = 0; ad_cnt = 0;
    sck_toggle(40);
    repeat (8) @(negedge clk);
    check("R4 idle op", op_cnt, 0);
    check("R4 idle addr", ad_cnt, 0);

    // R4: partial frame discarded, then a clean frame restarts at bit 0
    frame(1'b0, 48'hFF_FFFFFF_0000, 20);
    check("R4 partial op", op_cnt, 1);
    check("R4 partial addr", ad_cnt, 0);
    frame(1'b0, 48'h12_000A03_0000, 32);
    check("R4 restart opcode", op_seen, 8'h12);
    check("R4 restart page", pg_seen, 5);
    check("R4 restart byte", by_seen, 3);

    // R2: frame shorter than an opcode
    frame(1'b0, 48'hAA_000000_0000, 5);
    check("R2 short op", op_cnt, 0);
    check("R2 short addr", ad_cnt, 0);

    // R3: data-phase bits after the address are ignored
    frame(1'b1, 48'h0B_012C10_A5F0, 44);
    check("R3 long op", op_cnt, 1);
    check("R3 long addr", ad_cnt, 1);
    check("R3 long page", pg_seen, 300);
    check("R3 long byte", by_seen, 16);

    summary();
  end
endmodule